// File: doc/BRIEF.md
# Match-Compare Event Timer

This block is an up-counting timer behind a small register bank on a plain memory-mapped bus: a write strobe, a read strobe, a byte offset and 32-bit data in each direction. Software uses it in two ways. As a one-shot event source, it zeroes the count, loads a compare value, then sets the run bit. The block raises a one-cycle interrupt pulse when the count reaches the compare value, and the handler clears the run bit. As a continuous time source, it simply runs and software reads the count, which wraps from all-ones to zero.

A control bit can send the count back to zero on a match, which turns the timer into a periodic tick source with a period of compare value plus one ticks. A separate clock-control register selects whether the count advances on every clock or on every fourth clock. Writing anything to the clear offset restarts both the count and the prescaler. Reads return combinationally in the same cycle as the read strobe.

Top module: `mmt_timer`

## Requirements
- R1: Control register (offset 0x08) bit 0 is the run bit. While it is 0 the count holds its value. While it is 1 the count advances on every tick. Control bit 1 reads back at bit 1 and bit 0 at bit 0, and all other read bits are zero.
- R2: The compare register (offset 0x00) reads back the last value written. The count reads at offset 0x04, zero-extended to 32 bits.
- R3: A write of any data to offset 0x0C sets the count and the prescaler to zero at that clock edge. This takes priority over a tick in the same cycle, and it suppresses an interrupt in the same cycle.
- R4: Each tick adds one to the count modulo 2^CNT_W, so the all-ones value is followed by zero.
- R5: With control bit 1 set, a tick taken while the count equals the compare value loads zero instead of count+1. The count period is then compare value + 1 ticks.
- R6: `evt_irq` is high for exactly one cycle. That cycle is the one after the clock edge where a tick is taken while the count equals the compare value. With control bit 1 clear, the count runs past the compare value and no further pulse occurs until the count comes round again.
- R7: Writing exactly 3 to the clock-control register (offset 0x30) makes a tick occur on every fourth clock while running, and the register then reads 3. Any other written value selects a tick on every clock and reads 0.
- R8: A synchronous active-high `rst` zeroes every register and the prescaler, stops the timer and holds `evt_irq` low.
- R9: Reads of any other offset return zero, `bus_rdata` is zero while `bus_rd` is low, and writes to offset 0x04 or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (6) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational, zero when no read |
| evt_irq | output | 1 | One-cycle match pulse |

## Verification
The bench drives the count past all-ones on a narrowed counter. A design that saturated at all-ones, or skipped zero after it, would diverge from the model there. It places a clear write in the cycle where the count sits on the compare value. If the clear lost priority, the design would either emit a stray pulse or step the count to one. It runs the periodic mode with the divide-by-four prescaler, where an off-by-one in the prescale compare or in the wrap value shifts every later pulse by whole cycles. It also writes junk to the count offset and to holes in the map, and a decode that aliased them would corrupt the compare value or the count.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
    // Byte offsets of the register bank; the counter behaviour does not depend on them.
    localparam int OFS_MATCH  = 'h00;
    localparam int OFS_COUNT  = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_CLEAR  = 'h0C;
    localparam int OFS_CLKCTL = 'h30;
    // Clock-control code that selects the slow tick.
    localparam int DIV_CODE   = 3;
    // Control register bit positions.
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_WRAP_BIT = 1;
endpackage

// File: rtl/mmt_regbank.sv
module mmt_regbank
    import mmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  match,
    output logic              run,
    output logic              wrap_on_hit,
    output logic              div_sel,
    output logic              clr_req
);
    localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(OFS_MATCH);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_CLKCTL = ADDR_W'(OFS_CLKCTL);

    typedef struct packed {
        logic [CNT_W-1:0] match;
        logic             run;
        logic             wrap;
        logic             div;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == A_MATCH) begin
                r_d.match = wdata[CNT_W-1:0];
            end
            if (addr == A_CTRL) begin
                r_d.run  = wdata[CTRL_RUN_BIT];
                r_d.wrap = wdata[CTRL_WRAP_BIT];
            end
            if (addr == A_CLKCTL) begin
                r_d.div = (wdata == DATA_W'(DIV_CODE));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_MATCH:  rdata[CNT_W-1:0] = r_q.match;
                A_COUNT:  rdata[CNT_W-1:0] = count;
                A_CTRL: begin
                    rdata[CTRL_RUN_BIT]  = r_q.run;
                    rdata[CTRL_WRAP_BIT] = r_q.wrap;
                end
                A_CLKCTL: rdata = r_q.div ? DATA_W'(DIV_CODE) : '0;
                default:  rdata = '0;
            endcase
        end
    end

    assign match       = r_q.match;
    assign run         = r_q.run;
    assign wrap_on_hit = r_q.wrap;
    assign div_sel     = r_q.div;
    assign clr_req     = wr_en && (addr == A_CLEAR);
endmodule

// File: rtl/mmt_prescale.sv
module mmt_prescale #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic div_sel,
    input  logic clr,
    output logic tick
);
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                 cnt_d = '0;
        else if (run && div_sel) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign tick = run && (!div_sel || (cnt_q == PRE_LAST));
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] match,
    input  logic             wrap_on_hit,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq;
    } cnt_t;

    cnt_t s_d, s_q;
    logic at_match;

    always_comb begin
        s_d      = s_q;
        at_match = (s_q.count == match);
        s_d.irq  = tick && at_match && !clr;
        if (clr) begin
            s_d.count = '0;
        end else if (tick) begin
            if (wrap_on_hit && at_match) s_d.count = '0;
            else                         s_d.count = s_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign count = s_q.count;
    assign irq   = s_q.irq;
endmodule

// File: rtl/mmt_timer.sv
module mmt_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              evt_irq
);
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] match_val;
    logic             run_en;
    logic             wrap_en;
    logic             div_en;
    logic             clr_req;
    logic             tick;

    mmt_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .count(cnt_val), .rdata(bus_rdata), .match(match_val),
        .run(run_en), .wrap_on_hit(wrap_en), .div_sel(div_en), .clr_req(clr_req)
    );

    mmt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .run(run_en), .div_sel(div_en), .clr(clr_req), .tick(tick)
    );

    mmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .clr(clr_req), .match(match_val),
        .wrap_on_hit(wrap_en), .count(cnt_val), .irq(evt_irq)
    );
endmodule

// File: rtl/mmt_timer_chk.sv
module mmt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] match,
    input logic             run,
    input logic             wrap_on_hit,
    input logic             tick,
    input logic             clr,
    input logic             irq
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(count)); // R1

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && !(wrap_on_hit && count == match)) |=> (count == $past(count) + 1'b1)); // R4

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(wrap_on_hit)) |-> (count == '0)); // R5

    AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(count) == $past(match) && $past(run))); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (count == '0 && !irq)); // R8
endmodule

bind mmt_timer mmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .count(cnt_val), .match(match_val), .run(run_en),
    .wrap_on_hit(wrap_en), .tick(tick), .clr(clr_req), .irq(evt_irq)
);

// File: tb/mmt_timer_test.sv
`timescale 1ns/1ps
module mmt_timer_test;
    localparam int CW = 10;
    localparam longint MASK = (64'd1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_irq;

    int total = 0;
    int bad = 0;
    string cur_req = "R8";

    longint m_count = 0, m_match = 0;
    int m_run = 0, m_wrap = 0, m_div = 0, m_pre = 0, m_irq = 0;

    always #4 clk = ~clk;

    mmt_timer #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_irq(evt_irq)
    );

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_count = 0; m_match = 0; m_run = 0; m_wrap = 0; m_div = 0; m_pre = 0; m_irq = 0;
        end else begin
            bit clr, tk, hit;
            clr = bus_wr && bus_addr == 6'h0C;
            tk  = m_run != 0 && (m_div == 0 || m_pre == 3);
            hit = tk && m_count == m_match;
            m_irq = (hit && !clr) ? 1 : 0;
            if (clr) m_count = 0;
            else if (tk) m_count = (m_wrap != 0 && hit) ? 0 : ((m_count + 1) & MASK);
            if (clr) m_pre = 0;
            else if (m_run != 0 && m_div != 0) m_pre = (m_pre + 1) % 4;
            if (bus_wr) begin
                if (bus_addr == 6'h00) m_match = bus_wdata & MASK;
                if (bus_addr == 6'h08) begin m_run = bus_wdata[0]; m_wrap = bus_wdata[1]; end
                if (bus_addr == 6'h30) m_div = (bus_wdata == 32'd3) ? 1 : 0;
            end
        end
    end

    function automatic longint exp_rdata();
        if (!bus_rd) return 0;
        case (bus_addr)
            6'h00: return m_match;
            6'h04: return m_count;
            6'h08: return m_wrap * 2 + m_run;
            6'h30: return m_div != 0 ? 3 : 0;
            default: return 0;
        endcase
    endfunction

    // Compare every cycle, midway between edges.
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            total++;
            if (evt_irq !== m_irq[0]) begin
                bad++;
                $display("FAIL %s irq act=%0d exp=%0d t=%0t", cur_req, evt_irq, m_irq, $time);
            end
            total++;
            if (longint'(bus_rdata) !== exp_rdata()) begin
                bad++;
                $display("FAIL %s rdata@%0h act=%0h exp=%0h t=%0t", cur_req, bus_addr, bus_rdata, exp_rdata(), $time);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [5:0] a);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) rd(6'h04);
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset values of every register
        cur_req = "R8";
        rd(6'h00); rd(6'h04); rd(6'h08); rd(6'h30);
        // R2: compare register read-back
        cur_req = "R2";
        wr(6'h00, 32'h155); rd(6'h00); wr(6'h00, 32'h2AA); rd(6'h00);
        // R9: count writes and holes ignored, strobe gating
        cur_req = "R9";
        wr(6'h04, 32'h77); rd(6'h04); wr(6'h10, 32'hFFFF); wr(6'h3C, 32'h5);
        rd(6'h10); rd(6'h3C); rd(6'h00); rd(6'h08);
        @(negedge clk); bus_rd = 1'b0; bus_addr = 6'h00;
        @(negedge clk);
        // R1 and R4: run, then halt and hold
        cur_req = "R1";
        wr(6'h0C, 32'h0); wr(6'h00, 32'h3FF); wr(6'h08, 32'h1); idle(20);
        wr(6'h08, 32'h0); idle(10); rd(6'h08);
        // R6: one-shot pulse
        cur_req = "R6";
        wr(6'h0C, 32'h0); wr(6'h00, 32'd30); wr(6'h08, 32'h1); idle(60);
        wr(6'h08, 32'h0);
        // R5: periodic wrap
        cur_req = "R5";
        wr(6'h0C, 32'h0); wr(6'h00, 32'd7); wr(6'h08, 32'h3); idle(40); rd(6'h08);
        // R7: divide by four, then other codes
        cur_req = "R7";
        wr(6'h08, 32'h0); wr(6'h30, 32'h3); rd(6'h30);
        wr(6'h0C, 32'h0); wr(6'h00, 32'd5); wr(6'h08, 32'h3); idle(60);
        wr(6'h30, 32'h2); rd(6'h30); idle(15); wr(6'h30, 32'h103); rd(6'h30); idle(5);
        // R3: clear with junk data, and clear on the match cycle
        cur_req = "R3";
        wr(6'h08, 32'h1); wr(6'h00, 32'd12); wr(6'h0C, 32'hDEADBEEF); idle(12);
        wr(6'h0C, 32'h0); idle(8);
        wr(6'h30, 32'h3); wr(6'h0C, 32'h1); idle(6); wr(6'h0C, 32'h0); idle(10);
        wr(6'h30, 32'h0);
        // R4: roll over from all-ones to zero
        cur_req = "R4";
        wr(6'h08, 32'h0); wr(6'h0C, 32'h0); wr(6'h00, 32'h3FF); wr(6'h08, 32'h1);
        idle(1040);
        wr(6'h08, 32'h0); idle(3);
        // R8: reset mid-run
        cur_req = "R8";
        wr(6'h08, 32'h3); idle(5);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        rd(6'h04); rd(6'h08); rd(6'h00); idle(3);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule